// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block models a byte-organized serial EEPROM that sits on a two-wire I2C bus as a target. It samples the open-drain clock and data lines in its own clock domain and finds start and stop conditions. It answers only to its own device-select byte. A write transaction sets the word address. Any data bytes that follow go into a 16-byte page buffer, and the following stop launches a self-timed commit of that buffer into the on-chip array.

Read transactions return data from the internal address counter. A random read is a write that carries only the address, then a repeated start and a read. A current-address read starts straight from the counter. A sequential read goes on for as long as the controller acknowledges.

While a commit is running, the block refuses its own address, so a controller can poll for the end of the write. A write-protect input lets transfers complete normally but keeps every array byte unchanged. The array size and the length of the commit are parameters. With more than 256 words, the word address takes two bytes, high byte first.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The first byte after a start is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i`; bit 0 set means read. On a mismatch the block never pulls SDA low until the next start, and the bytes that follow have no effect on the array.
- R2: A start condition (SDA falling while SCL is high) restarts byte reception from the device-select byte, even in the middle of a transaction. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R3: `sda_oe` changes only while SCL is low.
- R4: A write of one data byte followed by a stop stores that byte at the addressed word once the commit ends.
- R5: Data bytes of a write go to consecutive words. The low 4 address bits wrap inside the current 16-byte page, so byte 17 and later overwrite the earliest buffered bytes, and no word outside the page changes.
- R6: A write that carries only the address bytes and then a stop loads the address counter without starting a commit. A repeated start and a read then return the word at that address.
- R7: During a read, the address counter advances after every byte sent and wraps from the top word to word 0. A not-acknowledge from the controller ends the read.
- R8: A current-address read returns the word one past the last word read, or one past the last word written.
- R9: For `WRITE_CYCLES` clock cycles after the stop that ends a write with data, the device-select byte is not acknowledged. Afterwards it is acknowledged again and the page buffer is empty.
- R10: While `wp_i` is high, address and data bytes are still acknowledged, but no array word changes.
- R11: After reset, `sda_oe` is low and every array word reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, sampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| strap_i | input | 3 | Device-select value compared with byte bits 3..1 |
| wp_i | input | 1 | Write protect, high keeps the array unchanged |

## Verification
Four properties are checked on every cycle:
- SDA is only released or pulled while SCL is low.
- While a commit runs, the protocol machine is never in an address, data or read phase.
- The page buffer is empty once a commit ends.
- Array write strobes never fire while protection is on.

Start and stop handling, the page bounds of buffer loads, and the select-byte match behind each acknowledge are also checked cycle by cycle.

Only the bench scenarios can show which bytes end up where. That covers page wrap with overwrite, rollover of the read address from the top word to 0, and the current-address position after reads and writes. It also covers the refused poll during a commit and the unchanged contents after a protected or mis-addressed write.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] TYPE_CODE  = 4'b1010;
  localparam int         PAGE_BYTES = 16;
  localparam int         PAGE_AW    = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA
  } phase_e;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign scl_lvl   = scl_sync[1];
  assign sda_lvl   = sda_sync[1];
  assign scl_rise  = !scl_d && scl_lvl;
  assign scl_fall  = scl_d && !scl_lvl;
  assign start_evt = scl_d && scl_lvl && sda_d && !sda_lvl;
  assign stop_evt  = scl_d && scl_lvl && !sda_d && sda_lvl;

  // R2
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !(scl_rise || scl_fall));
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int PW           = 7,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            buf_clear,
  input  logic                            buf_load,
  input  logic [PAGE_AW-1:0]              load_idx,
  input  logic [7:0]                      load_data,
  input  logic                            commit_req,
  input  logic [PW-1:0]                   page_in,
  input  logic                            wp_i,
  output logic                            busy,
  output logic [PAGE_BYTES-1:0]           wr_mask,
  output logic [PW-1:0]                   wr_page,
  output logic [PAGE_BYTES-1:0][7:0]      wr_bytes
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [7:0]    slot   [PAGE_BYTES];
  logic          slot_v [PAGE_BYTES];
  logic [CW-1:0] cnt;
  logic          fire;
  logic          any_valid;

  assign fire = busy && (cnt == '0);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g]   <= 8'h00;
        slot_v[g] <= 1'b0;
      end else if (buf_clear || fire) begin
        slot_v[g] <= 1'b0;
      end else if (buf_load && load_idx == PAGE_AW'(g)) begin
        slot[g]   <= load_data;
        slot_v[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      any_valid   = any_valid | slot_v[i];
      wr_mask[i]  = fire && !wp_i && slot_v[i];
      wr_bytes[i] = slot[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      wr_page <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (commit_req && any_valid) begin
      busy    <= 1'b1;
      cnt     <= CW'(WRITE_CYCLES - 1);
      wr_page <= page_in;
    end
  end

  // R9
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |-> !busy);

  // R9
  clear_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_valid);
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int WORDS = 2048,
  parameter int PW    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PAGE_BYTES-1:0]      wr_mask,
  input  logic [PW-1:0]              wr_page,
  input  logic [PAGE_BYTES-1:0][7:0] wr_bytes,
  input  logic                       wp_i,
  input  logic [PW+PAGE_AW-1:0]      rd_addr,
  output logic [7:0]                 rd_data
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
    end else begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (wr_mask[j]) mem[{wr_page, PAGE_AW'(j)}] <= wr_bytes[j];
    end
  end

  assign rd_data = mem[rd_addr];

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_mask) |-> !wp_i);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int MEM_WORDS    = 2048,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int AW     = $clog2(MEM_WORDS);
  localparam int ABYTES = (AW + 7) / 8;
  localparam int PW     = AW - PAGE_AW;

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    return {a[AW-1:PAGE_AW], a[PAGE_AW-1:0] + 1'b1};
  endfunction

  function automatic logic [AW-1:0] addr_push(input logic [AW-1:0] a, input logic [7:0] b);
    logic [AW+7:0] t;
    t = {a, b};
    return t[AW-1:0];
  endfunction

  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] s);
    return (b[7:4] == TYPE_CODE) && (b[3:1] == s);
  endfunction

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  phase_e          phase, after_ack;
  logic [3:0]      bitcnt;
  logic            ack_ph, acked, mack;
  logic [7:0]      shreg, rd_sh;
  logic [AW-1:0]   addr;
  logic [1:0]      abyte;

  logic            rx_phase, byte_done, dev_take;
  logic            buf_clear, buf_load, commit_req, busy;
  logic [PAGE_BYTES-1:0]      wr_mask;
  logic [PW-1:0]              wr_page;
  logic [PAGE_BYTES-1:0][7:0] wr_bytes;
  logic [7:0]                 rd_data;

  assign rx_phase   = (phase == PH_DEV) || (phase == PH_WADDR) || (phase == PH_WDATA);
  assign byte_done  = rx_phase && scl_fall && !ack_ph && (bitcnt == 4'd8);
  assign dev_take   = dev_match(shreg, strap_i) && !busy;
  assign buf_clear  = byte_done && (phase == PH_DEV) && dev_take && !shreg[0];
  assign buf_load   = byte_done && (phase == PH_WDATA);
  assign commit_req = stop_evt && (phase == PH_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      after_ack <= PH_IDLE;
      bitcnt    <= '0;
      ack_ph    <= 1'b0;
      acked     <= 1'b0;
      mack      <= 1'b0;
      shreg     <= '0;
      rd_sh     <= '0;
      addr      <= '0;
      abyte     <= '0;
      sda_oe    <= 1'b0;
    end else if (start_evt) begin
      phase  <= PH_DEV;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (rx_phase) begin
      if (scl_rise && !ack_ph) begin
        shreg  <= {shreg[6:0], sda_lvl};
        bitcnt <= bitcnt + 4'd1;
      end else if (byte_done) begin
        ack_ph <= 1'b1;
        unique case (phase)
          PH_DEV: begin
            sda_oe    <= dev_take;
            acked     <= dev_take;
            after_ack <= shreg[0] ? PH_RDATA : PH_WADDR;
            abyte     <= '0;
          end
          PH_WADDR: begin
            sda_oe <= 1'b1;
            acked  <= 1'b1;
            addr   <= addr_push(addr, shreg);
            if (abyte == 2'(ABYTES - 1)) begin
              after_ack <= PH_WDATA;
            end else begin
              abyte     <= abyte + 2'd1;
              after_ack <= PH_WADDR;
            end
          end
          default: begin
            sda_oe    <= 1'b1;
            acked     <= 1'b1;
            addr      <= page_next(addr);
            after_ack <= PH_WDATA;
          end
        endcase
      end else if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        bitcnt <= '0;
        if (!acked) begin
          phase  <= PH_IDLE;
          sda_oe <= 1'b0;
        end else if (after_ack == PH_RDATA) begin
          phase  <= PH_RDATA;
          rd_sh  <= rd_data;
          sda_oe <= !rd_data[7];
        end else begin
          phase  <= after_ack;
          sda_oe <= 1'b0;
        end
      end
    end else if (phase == PH_RDATA) begin
      if (scl_rise) begin
        if (ack_ph) mack   <= !sda_lvl;
        else        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0;
          bitcnt <= '0;
          if (mack) begin
            rd_sh  <= rd_data;
            sda_oe <= !rd_data[7];
          end else begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          ack_ph <= 1'b1;
          sda_oe <= 1'b0;
          addr   <= seq_next(addr);
        end else begin
          rd_sh  <= {rd_sh[6:0], 1'b0};
          sda_oe <= !rd_sh[6];
        end
      end
    end
  end

  eep_store #(.PW(PW), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_load(buf_load),
    .load_idx(addr[PAGE_AW-1:0]), .load_data(shreg), .commit_req(commit_req),
    .page_in(addr[AW-1:PAGE_AW]), .wp_i(wp_i), .busy(busy),
    .wr_mask(wr_mask), .wr_page(wr_page), .wr_bytes(wr_bytes)
  );

  eep_array #(.WORDS(MEM_WORDS), .PW(PW)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_page(wr_page),
    .wr_bytes(wr_bytes), .wp_i(wp_i), .rd_addr(addr), .rd_data(rd_data)
  );

  // R3
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R1
  dev_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV && ack_ph && sda_oe) |-> dev_match(shreg, strap_i));

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_DEV && bitcnt == 4'd0 && !sda_oe));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (phase == PH_IDLE));

  // R9
  busy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase == PH_IDLE || phase == PH_DEV));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> (addr[AW-1:PAGE_AW] == $past(addr[AW-1:PAGE_AW])));
endmodule

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
  localparam int MEM_WORDS    = 2048;
  localparam int WRITE_CYCLES = 2000;
  localparam int Q            = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_tb = 1'b1;
  logic sda_tb = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int r3_viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  logic [7:0] rd_buf [32];

  always #10 clk = ~clk;

  assign sda_line = sda_tb & ~sda_oe;

  i2c_eeprom_target #(.MEM_WORDS(MEM_WORDS), .WRITE_CYCLES(WRITE_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  // R3 monitor at the pins
  always @(negedge clk) begin
    if (rst_n && scl_tb && (sda_oe !== oe_prev)) r3_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_tb = 1'b1; wq();
    scl_tb = 1'b1; wq();
    sda_tb = 1'b0; wq();
    scl_tb = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_tb = 1'b0; wq();
    scl_tb = 1'b1; wq();
    sda_tb = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_tb = b[i]; wq();
      scl_tb = 1'b1; wq(); wq();
      scl_tb = 1'b0;
    end
    sda_tb = 1'b1; wq();
    scl_tb = 1'b1; wq();
    ack = !sda_line; wq();
    scl_tb = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_tb = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_tb = 1'b1; wq();
      b[i] = sda_line; wq();
      scl_tb = 1'b0;
    end
    wq();
    sda_tb = !ack; wq();
    scl_tb = 1'b1; wq(); wq();
    scl_tb = 1'b0; wq();
    sda_tb = 1'b1;
  endtask

  task automatic wait_commit();
    repeat (WRITE_CYCLES + 50) @(negedge clk);
  endtask

  task automatic write_seq(input logic [10:0] a, input int n, input logic [7:0] base, output int nacks);
    bit ak;
    nacks = 0;
    bus_start();
    send_byte(DEV_W, ak); if (!ak) nacks++;
    send_byte({5'b0, a[10:8]}, ak); if (!ak) nacks++;
    send_byte(a[7:0], ak); if (!ak) nacks++;
    for (int k = 0; k < n; k++) begin
      send_byte(base + 8'(k), ak); if (!ak) nacks++;
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [10:0] a, input int n, output int nacks);
    bit ak;
    nacks = 0;
    bus_start();
    send_byte(DEV_W, ak); if (!ak) nacks++;
    send_byte({5'b0, a[10:8]}, ak); if (!ak) nacks++;
    send_byte(a[7:0], ak); if (!ak) nacks++;
    bus_start();
    send_byte(DEV_R, ak); if (!ak) nacks++;
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rd_buf[k]);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] b, output bit ak);
    bus_start();
    send_byte(DEV_R, ak);
    recv_byte(1'b0, b);
    bus_stop();
  endtask

  task automatic t_reset();
    int nk;
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    read_seq(11'h555, 1, nk);
    chk(rd_buf[0] == 8'hFF, "R11 erased word", rd_buf[0], 8'hFF);
  endtask

  task automatic t_byte_write();
    int nk;
    logic [7:0] b;
    bit ak;
    write_seq(11'h123, 1, 8'h5A, nk);
    chk(nk == 0, "R4 write acks", nk, 0);
    wait_commit();
    read_seq(11'h123, 1, nk);
    chk(nk == 0 && rd_buf[0] == 8'h5A, "R4 byte stored", rd_buf[0], 8'h5A);
    cur_read(b, ak);
    chk(ak && b == 8'hFF, "R8 current after read", b, 8'hFF);
  endtask

  task automatic t_busy_poll();
    int nk;
    bit ak;
    write_seq(11'h040, 1, 8'h11, nk);
    bus_start();
    send_byte(DEV_W, ak);
    bus_stop();
    chk(!ak, "R9 nack while committing", ak, 0);
    wait_commit();
    bus_start();
    send_byte(DEV_W, ak);
    bus_stop();
    chk(ak, "R9 ack after commit", ak, 1);
    read_seq(11'h040, 1, nk);
    chk(rd_buf[0] == 8'h11, "R9 data committed", rd_buf[0], 8'h11);
  endtask

  task automatic t_protect();
    int nk;
    wp = 1'b1;
    write_seq(11'h123, 3, 8'h99, nk);
    chk(nk == 0, "R10 acks under protect", nk, 0);
    wait_commit();
    wp = 1'b0;
    read_seq(11'h123, 2, nk);
    chk(rd_buf[0] == 8'h5A, "R10 word unchanged", rd_buf[0], 8'h5A);
    chk(rd_buf[1] == 8'hFF, "R10 next word unchanged", rd_buf[1], 8'hFF);
  endtask

  task automatic t_mismatch();
    int nk;
    bit ak;
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, ak);
    chk(!ak, "R1 wrong strap nack", ak, 0);
    send_byte(8'h01, ak);
    send_byte(8'h23, ak);
    send_byte(8'h00, ak);
    chk(!ak, "R1 data ignored nack", ak, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ak);
    chk(!ak, "R1 wrong type nack", ak, 0);
    bus_stop();
    read_seq(11'h123, 1, nk);
    chk(nk == 0 && rd_buf[0] == 8'h5A, "R1 array untouched", rd_buf[0], 8'h5A);
  endtask

  task automatic t_page();
    int nk;
    logic [7:0] exp_pg [16];
    logic [7:0] b;
    bit ak;
    for (int p = 0; p < 16; p++) exp_pg[p] = 8'hFF;
    for (int k = 0; k < 18; k++) exp_pg[(5 + k) % 16] = 8'h80 + 8'(k);
    write_seq(11'h2F5, 18, 8'h80, nk);
    chk(nk == 0, "R5 page acks", nk, 0);
    wait_commit();
    cur_read(b, ak);
    chk(ak && b == 8'h82, "R8 current after page", b, 8'h82);
    read_seq(11'h2F0, 16, nk);
    for (int p = 0; p < 16; p++)
      chk(rd_buf[p] == exp_pg[p], "R5 page word", rd_buf[p], exp_pg[p]);
    read_seq(11'h2EF, 1, nk);
    chk(rd_buf[0] == 8'hFF, "R5 below page", rd_buf[0], 8'hFF);
    read_seq(11'h300, 1, nk);
    chk(rd_buf[0] == 8'hFF, "R5 above page", rd_buf[0], 8'hFF);
  endtask

  task automatic t_rollover();
    int nk;
    logic [7:0] b;
    bit ak;
    write_seq(11'h7FF, 1, 8'hA7, nk);
    wait_commit();
    write_seq(11'h000, 1, 8'h3C, nk);
    wait_commit();
    read_seq(11'h7FE, 3, nk);
    chk(rd_buf[0] == 8'hFF, "R7 word 7FE", rd_buf[0], 8'hFF);
    chk(rd_buf[1] == 8'hA7, "R7 top word", rd_buf[1], 8'hA7);
    chk(rd_buf[2] == 8'h3C, "R7 wrapped to 0", rd_buf[2], 8'h3C);
    cur_read(b, ak);
    chk(ak && b == 8'hFF, "R8 current after wrap", b, 8'hFF);
  endtask

  task automatic t_restart();
    bit ak;
    logic [7:0] b;
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'h02, ak);
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'h01, ak);
    send_byte(8'h23, ak);
    bus_start();
    send_byte(DEV_R, ak);
    chk(ak, "R2 ack after restarts", ak, 1);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == 8'h5A, "R2 restart read", b, 8'h5A);
  endtask

  task automatic t_addr_only();
    bit ak;
    logic [7:0] b;
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'h02, ak);
    send_byte(8'hF3, ak);
    bus_stop();
    cur_read(b, ak);
    chk(ak, "R6 no commit after address-only", ak, 1);
    chk(b == 8'h8E, "R6 address loaded", b, 8'h8E);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_busy_poll();
    t_protect();
    t_mismatch();
    t_page();
    t_rollover();
    t_restart();
    t_addr_only();
    chk(r3_viol == 0, "R3 sda change with scl high", r3_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule